// File: doc/BRIEF.md
# Interrupt Flag and Mode Controller

This block keeps the interrupt cause flags and the interrupt mode bits of a processor that changes context by swapping a saved state package. Each of the nine flag bits records one cause. Raw event pulses set flags, but only when the mode bits allow them. Separate enables cover correctable memory errors, uncorrectable memory errors and floating-point errors, and a monitor-mode bit adds a further gate on top of them. As soon as any flag holds a 1, the block raises an interrupt request, and the exchange sequencer that receives it swaps in a new package.

The flags, the mode bits and a monitor-select bit are loaded in a single cycle from an incoming package. They are always visible on the save ports, ready to be written into the outgoing package. Two instruction codes set and clear the floating-point error enable while a program runs. The other mode bits change only on a package load. A parameter picks the monitor behaviour. In the basic variant, monitor mode blocks every flag except the two memory-error flags. In the optional variant, the monitor-select bit chooses one of two 9-bit permit masks that come in on ports.

The request comes from a two-state machine. QUIET drives the request low and REQUEST drives it high. Transition RAISE goes from QUIET to REQUEST when the next flag value is non-zero. Transition DROP goes from REQUEST to QUIET when a package load brings all-zero flags and no event is accepted in that cycle.

Top module: `intflag_ctrl`

## Requirements
- R1: After reset, all flags, all mode bits and the monitor-select bit are 0, and irq_o is low.
- R2: irq_o is high in exactly those cycles in which at least one flag bit is 1. A flag taken at a clock edge is seen on save_flags_o and irq_o after that same edge.
- R3: event_i[0] (correctable memory error) can set flag 0 only while mode bit 0 (correctable enable) is 1.
- R4: event_i[1] (uncorrectable memory error) can set flag 1 only while mode bit 2 (uncorrectable enable) is 1.
- R5: event_i[2] (floating-point error) can set flag 2 only while mode bit 1 (floating-point enable) is 1.
- R6: With MONITOR_OPT=0, while mode bit 3 (monitor) is 1, flags 2 to 8 cannot be set. Flags 0 and 1 stay under R3 and R4.
- R7: With MONITOR_OPT=1, while mode bit 3 is 1, an event can set a flag only if its bit is 1 in mon_mask_a_i (select bit 0) or in mon_mask_b_i (select bit 1). R3 to R5 still apply.
- R8: Without a load, instr_valid_i with opcode_i equal to octal 0021 sets mode bit 1, and octal 0022 clears it. Any other code leaves all mode bits unchanged.
- R9: Mode bits 0, 2 and 3 and the monitor-select bit change only in a package load cycle.
- R10: Flags are sticky. A package load replaces the flags, the modes and the select bit with the package values.
- R11: A load whose package flags are non-zero drives irq_o high after that edge.
- R12: In a load cycle, the accepted events are ORed into the loaded flags. Acceptance uses the mode bits that were in effect before the load.
- R13: In a load cycle, an instruction is ignored and the modes come from the package.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_i | input | 9 | Raw cause pulses, one per flag |
| pkg_load_i | input | 1 | Load the incoming state package this cycle |
| pkg_flags_i | input | 9 | Flags of the incoming package |
| pkg_modes_i | input | 4 | Modes of the incoming package: bit0 correctable, bit1 floating-point, bit2 uncorrectable, bit3 monitor |
| pkg_msel_i | input | 1 | Monitor-select bit of the incoming package |
| instr_valid_i | input | 1 | An instruction is issued this cycle |
| opcode_i | input | 12 | Instruction code |
| mon_mask_a_i | input | 9 | Flags permitted in monitor mode when select is 0 (MONITOR_OPT=1) |
| mon_mask_b_i | input | 9 | Flags permitted in monitor mode when select is 1 (MONITOR_OPT=1) |
| irq_o | output | 1 | Interrupt request to the exchange sequencer |
| save_flags_o | output | 9 | Flags for the outgoing package |
| save_modes_o | output | 4 | Modes for the outgoing package |
| save_msel_o | output | 1 | Monitor-select bit for the outgoing package |

## Verification
The assertions check the following on every cycle:
- the request agrees with the flags, and a non-zero package load raises it;
- flags stay sticky between loads;
- the correctable and floating-point enables gate their flags;
- the basic monitor inhibit holds;
- the load-only mode bits stay stable;
- the set opcode works.

Only the bench scenarios can show the mask selection of the optional monitor variant, the use of the pre-load modes in a load cycle, and the precedence of a load over an instruction. The bench runs both variants side by side against a reference model.

// File: rtl/intflag_pkg.sv
package intflag_pkg;
    localparam int NUM_FLAGS = 9;
    localparam int OP_W      = 12;

    localparam int IDX_CORR   = 0;
    localparam int IDX_UNCORR = 1;
    localparam int IDX_FPE    = 2;

    localparam logic [OP_W-1:0] OP_FPE_SET = 12'o0021;
    localparam logic [OP_W-1:0] OP_FPE_CLR = 12'o0022;

    typedef struct packed {
        logic monitor;
        logic uncorr_en;
        logic fpe_en;
        logic corr_en;
    } mode_t;

    typedef enum logic {
        ST_QUIET   = 1'b0,
        ST_REQUEST = 1'b1
    } req_state_t;
endpackage

// File: rtl/intflag_modereg.sv
module intflag_modereg
    import intflag_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  mode_t          load_modes,
    input  logic           load_msel,
    input  logic           instr_valid,
    input  logic [OPW-1:0] opcode,
    output mode_t          modes,
    output logic           msel
);
    localparam logic [OPW-1:0] SET_CODE = OPW'(OP_FPE_SET);
    localparam logic [OPW-1:0] CLR_CODE = OPW'(OP_FPE_CLR);

    mode_t modes_d;
    logic  msel_d;

    always_comb begin
        modes_d = modes;
        msel_d  = msel;
        if (load) begin
            modes_d = load_modes;
            msel_d  = load_msel;
        end else if (instr_valid) begin
            if (opcode == SET_CODE)
                modes_d.fpe_en = 1'b1;
            else if (opcode == CLR_CODE)
                modes_d.fpe_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            modes <= '0;
            msel  <= 1'b0;
        end else begin
            modes <= modes_d;
            msel  <= msel_d;
        end
    end
endmodule

// File: rtl/intflag_gate.sv
module intflag_gate
    import intflag_pkg::*;
#(
    parameter int NF          = NUM_FLAGS,
    parameter bit MONITOR_OPT = 1'b0
) (
    input  mode_t         modes,
    input  logic          msel,
    input  logic [NF-1:0] mask_a,
    input  logic [NF-1:0] mask_b,
    input  logic [NF-1:0] events,
    output logic [NF-1:0] accepted
);
    localparam logic [NF-1:0] MEM_ONLY =
        (NF'(1) << IDX_CORR) | (NF'(1) << IDX_UNCORR);

    logic [NF-1:0] mon_permit;
    logic [NF-1:0] permit;

    generate
        if (MONITOR_OPT) begin : g_masked_monitor
            assign mon_permit = msel ? mask_b : mask_a;
        end else begin : g_basic_monitor
            assign mon_permit = MEM_ONLY;
        end
    endgenerate

    always_comb begin
        permit             = '1;
        permit[IDX_CORR]   = modes.corr_en;
        permit[IDX_UNCORR] = modes.uncorr_en;
        permit[IDX_FPE]    = modes.fpe_en;
        if (modes.monitor)
            permit = permit & mon_permit;
        accepted = events & permit;
    end
endmodule

// File: rtl/intflag_flagreg.sv
module intflag_flagreg #(
    parameter int NF = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NF-1:0] load_flags,
    input  logic [NF-1:0] accepted,
    output logic [NF-1:0] flags_next,
    output logic [NF-1:0] flags
);
    assign flags_next = (load ? load_flags : flags) | accepted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= flags_next;
    end
endmodule

// File: rtl/intflag_ctrl.sv
module intflag_ctrl
    import intflag_pkg::*;
#(
    parameter int NF          = NUM_FLAGS,
    parameter int OPW         = OP_W,
    parameter bit MONITOR_OPT = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NF-1:0]  event_i,
    input  logic           pkg_load_i,
    input  logic [NF-1:0]  pkg_flags_i,
    input  logic [3:0]     pkg_modes_i,
    input  logic           pkg_msel_i,
    input  logic           instr_valid_i,
    input  logic [OPW-1:0] opcode_i,
    input  logic [NF-1:0]  mon_mask_a_i,
    input  logic [NF-1:0]  mon_mask_b_i,
    output logic           irq_o,
    output logic [NF-1:0]  save_flags_o,
    output logic [3:0]     save_modes_o,
    output logic           save_msel_o
);
    mode_t         modes;
    logic          msel;
    logic [NF-1:0] accepted;
    logic [NF-1:0] flags_next;
    req_state_t    state_q, state_d;

    intflag_modereg #(.OPW(OPW)) u_modes (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (pkg_load_i),
        .load_modes  (mode_t'(pkg_modes_i)),
        .load_msel   (pkg_msel_i),
        .instr_valid (instr_valid_i),
        .opcode      (opcode_i),
        .modes       (modes),
        .msel        (msel)
    );

    intflag_gate #(.NF(NF), .MONITOR_OPT(MONITOR_OPT)) u_gate (
        .modes    (modes),
        .msel     (msel),
        .mask_a   (mon_mask_a_i),
        .mask_b   (mon_mask_b_i),
        .events   (event_i),
        .accepted (accepted)
    );

    intflag_flagreg #(.NF(NF)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pkg_load_i),
        .load_flags (pkg_flags_i),
        .accepted   (accepted),
        .flags_next (flags_next),
        .flags      (save_flags_o)
    );

    // Request state machine: RAISE and DROP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (|flags_next) state_d = ST_REQUEST;
            ST_REQUEST: if (!(|flags_next)) state_d = ST_QUIET;
            default:    state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == ST_REQUEST);
    end

    assign save_modes_o = modes;
    assign save_msel_o  = msel;
endmodule

// File: rtl/intflag_ctrl_chk.sv
module intflag_ctrl_chk #(
    parameter int NF          = 9,
    parameter int OPW         = 12,
    parameter bit MONITOR_OPT = 1'b0
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NF-1:0]  event_i,
    input logic           pkg_load_i,
    input logic [NF-1:0]  pkg_flags_i,
    input logic           instr_valid_i,
    input logic [OPW-1:0] opcode_i,
    input logic           irq_o,
    input logic [NF-1:0]  save_flags_o,
    input logic [3:0]     save_modes_o,
    input logic           save_msel_o
);
    // R2
    irq_matches_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (save_flags_o != '0));

    // R11
    load_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkg_load_i && (pkg_flags_i != '0)) |=> irq_o);

    // R10
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkg_load_i |=> ((save_flags_o & $past(save_flags_o)) == $past(save_flags_o)));

    // R3
    corr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkg_load_i && !save_modes_o[0] && !save_flags_o[0]) |=> !save_flags_o[0]);

    // R5
    fpe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkg_load_i && !save_modes_o[1] && !save_flags_o[2]) |=> !save_flags_o[2]);

    // R9
    load_only_modes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkg_load_i |=> ($stable(save_modes_o[0]) && $stable(save_modes_o[2]) &&
                         $stable(save_modes_o[3]) && $stable(save_msel_o)));

    // R8
    fpe_set_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkg_load_i && instr_valid_i && opcode_i == OPW'(12'o0021)) |=> save_modes_o[1]);

    generate
        if (!MONITOR_OPT) begin : g_basic
            // R6
            monitor_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!pkg_load_i && save_modes_o[3] && save_flags_o[NF-1:2] == '0)
                |=> save_flags_o[NF-1:2] == '0);
        end
    endgenerate
endmodule

bind intflag_ctrl intflag_ctrl_chk #(.NF(NF), .OPW(OPW), .MONITOR_OPT(MONITOR_OPT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .event_i       (event_i),
    .pkg_load_i    (pkg_load_i),
    .pkg_flags_i   (pkg_flags_i),
    .instr_valid_i (instr_valid_i),
    .opcode_i      (opcode_i),
    .irq_o         (irq_o),
    .save_flags_o  (save_flags_o),
    .save_modes_o  (save_modes_o),
    .save_msel_o   (save_msel_o)
);

// File: tb/intflag_ctrl_test.sv
module intflag_ctrl_test;
    localparam logic [8:0] MASK_A = 9'h0F3;
    localparam logic [8:0] MASK_B = 9'h10C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  event_i = '0;
    logic        pkg_load_i = 1'b0;
    logic [8:0]  pkg_flags_i = '0;
    logic [3:0]  pkg_modes_i = '0;
    logic        pkg_msel_i = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [11:0] opcode_i = '0;
    logic        irq_b, irq_o2, msel_b, msel_o2;
    logic [8:0]  flags_b, flags_o2;
    logic [3:0]  modes_b, modes_o2;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // reference model state
    logic [8:0] m_flags0 = '0, m_flags1 = '0;
    logic [3:0] m_modes = '0;
    logic       m_msel = 1'b0;

    typedef struct packed {
        logic [8:0] f0;
        logic [8:0] f1;
        logic [3:0] md;
        logic       ms;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    intflag_ctrl #(.MONITOR_OPT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .event_i(event_i), .pkg_load_i(pkg_load_i),
        .pkg_flags_i(pkg_flags_i), .pkg_modes_i(pkg_modes_i), .pkg_msel_i(pkg_msel_i),
        .instr_valid_i(instr_valid_i), .opcode_i(opcode_i),
        .mon_mask_a_i(MASK_A), .mon_mask_b_i(MASK_B),
        .irq_o(irq_b), .save_flags_o(flags_b), .save_modes_o(modes_b), .save_msel_o(msel_b));

    intflag_ctrl #(.MONITOR_OPT(1'b1)) uut_opt (
        .clk(clk), .rst_n(rst_n), .event_i(event_i), .pkg_load_i(pkg_load_i),
        .pkg_flags_i(pkg_flags_i), .pkg_modes_i(pkg_modes_i), .pkg_msel_i(pkg_msel_i),
        .instr_valid_i(instr_valid_i), .opcode_i(opcode_i),
        .mon_mask_a_i(MASK_A), .mon_mask_b_i(MASK_B),
        .irq_o(irq_o2), .save_flags_o(flags_o2), .save_modes_o(modes_o2), .save_msel_o(msel_o2));

    // permitted flags per R3..R7
    function automatic logic [8:0] allowed(input bit opt, input logic [3:0] md, input logic ms);
        logic [8:0] a;
        a = 9'h1FF;
        a[0] = md[0];
        a[1] = md[2];
        a[2] = md[1];
        if (md[3]) begin
            if (opt) a = a & (ms ? MASK_B : MASK_A);
            else     a = a & 9'h003;
        end
        return a;
    endfunction

    task automatic step(input logic [8:0] ev, input logic ld, input logic [8:0] pf,
                        input logic [3:0] pm, input logic pms, input logic iv,
                        input logic [11:0] op, input string tag);
        exp_t e;
        logic [8:0] acc0, acc1;
        @(negedge clk);
        event_i = ev; pkg_load_i = ld; pkg_flags_i = pf; pkg_modes_i = pm;
        pkg_msel_i = pms; instr_valid_i = iv; opcode_i = op;
        acc0 = ev & allowed(1'b0, m_modes, m_msel);
        acc1 = ev & allowed(1'b1, m_modes, m_msel);
        if (ld) begin
            m_flags0 = pf | acc0;
            m_flags1 = pf | acc1;
            m_modes  = pm;
            m_msel   = pms;
        end else begin
            m_flags0 = m_flags0 | acc0;
            m_flags1 = m_flags1 | acc1;
            if (iv && op == 12'o0021) m_modes[1] = 1'b1;
            else if (iv && op == 12'o0022) m_modes[1] = 1'b0;
        end
        e.f0 = m_flags0; e.f1 = m_flags1; e.md = m_modes; e.ms = m_msel;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(9'h000, 1'b0, 9'h000, 4'h0, 1'b0, 1'b0, 12'o0, tag);
    endtask

    task automatic load(input logic [8:0] pf, input logic [3:0] pm, input logic pms,
                        input string tag);
        step(9'h000, 1'b1, pf, pm, pms, 1'b0, 12'o0, tag);
    endtask

    // monitor: compares one vector 2 ns after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (flags_b !== e.f0 || flags_o2 !== e.f1 || modes_b !== e.md ||
                modes_o2 !== e.md || msel_b !== e.ms || msel_o2 !== e.ms ||
                irq_b !== (|e.f0) || irq_o2 !== (|e.f1)) begin
                miscompares++;
                $display("FAIL %s: flags %h/%h modes %h/%h msel %b/%b irq %b/%b, expected flags %h/%h modes %h msel %b irq %b/%b",
                         t, flags_b, flags_o2, modes_b, modes_o2, msel_b, msel_o2,
                         irq_b, irq_o2, e.f0, e.f1, e.md, e.ms, |e.f0, |e.f1);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        // all enables off: gated causes ignored
        step(9'h001, 0, 0, 0, 0, 0, 12'o0, "R3 correctable blocked");
        step(9'h002, 0, 0, 0, 0, 0, 12'o0, "R4 uncorrectable blocked");
        step(9'h004, 0, 0, 0, 0, 0, 12'o0, "R5 fp blocked");
        step(9'h020, 0, 0, 0, 0, 0, 12'o0, "R2 flag 5 raises request");
        idle("R10 flag sticky");
        load(9'h000, 4'b0111, 1'b0, "R10 load clears flags, sets modes");
        step(9'h001, 0, 0, 0, 0, 0, 12'o0, "R3 correctable enabled");
        step(9'h002, 0, 0, 0, 0, 0, 12'o0, "R4 uncorrectable enabled");
        step(9'h004, 0, 0, 0, 0, 0, 12'o0, "R5 fp enabled");
        load(9'h000, 4'b0111, 1'b0, "R10 reload");
        step(9'h000, 0, 0, 0, 0, 1, 12'o0022, "R8 clear fp mode");
        step(9'h004, 0, 0, 0, 0, 0, 12'o0, "R5 fp blocked after clear");
        step(9'h000, 0, 0, 0, 0, 1, 12'o0023, "R8 other opcode no effect");
        step(9'h000, 0, 0, 0, 0, 1, 12'o0021, "R8 set fp mode");
        step(9'h004, 0, 0, 0, 0, 0, 12'o0, "R5 fp accepted after set");
        step(9'h1F8, 0, 0, 0, 0, 1, 12'o0077, "R9 modes unchanged by run events");
        load(9'h000, 4'b1111, 1'b0, "R9 monitor set by load");
        step(9'h1FF, 0, 0, 0, 0, 0, 12'o0, "R6 R7 monitor select 0");
        load(9'h000, 4'b1111, 1'b1, "R10 load select 1");
        step(9'h1FF, 0, 0, 0, 0, 0, 12'o0, "R6 R7 monitor select 1");
        load(9'h040, 4'b0000, 1'b0, "R11 reload with flag retriggers");
        load(9'h000, 4'b0000, 1'b0, "R10 request drops on clean load");
        step(9'h080, 1, 9'h000, 4'b0111, 0, 0, 12'o0, "R12 event ORed into load");
        load(9'h000, 4'b0000, 1'b0, "R10 clean load");
        step(9'h001, 1, 9'h000, 4'b0111, 0, 0, 12'o0, "R12 pre-load modes gate");
        step(9'h000, 1, 9'h000, 4'b0101, 0, 1, 12'o0021, "R13 load beats instruction");
        idle("R13 fp mode stays clear");
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule